// File: doc/BRIEF.md
# Sticky FIFO Event Status Unit

This block follows the occupancy of a transmit queue and a receive queue from their push and pop strobes. It keeps no data. From the occupancy it records events: a queue reaching empty, a queue reaching full, or a queue count landing on a programmable threshold. The receive queue has two independent thresholds. Each event sets a sticky flag. The flag stays set until a single clear-status command, so software that polls rarely still sees that an event took place.

The block also detects illegal accesses, which are a push to a full queue or a pop from an empty one. It ignores such an access and raises a pointer-error flag for that side. The clear-status command leaves pointer-error flags alone. Only a reset of the affected side (transmit or receive) removes them. A transmit-lock level is reported beside the event flags. All of these bits are packed into one read-only 32-bit status word.

Top module: `fifo_evt_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word becomes 0 at that edge. Bits 31 to 10 are always 0.
- R2: Bit 0 (TX empty) sets on the edge where the transmit count changes to 0. It stays set through later pushes until a clear.
- R3: Bit 1 (TX full) sets when the transmit count changes to DEPTH. Bit 4 (RX full) does the same for the receive count. Both are sticky.
- R4: Bit 2 (TX threshold) sets on the edge where the transmit count changes to a value equal to `tx_level`. It is sticky.
- R5: Bit 5 sets when the receive count changes to equal `rx_level_a`. Bit 9 sets when the receive count changes to equal `rx_level_b`. The two flags are independent and sticky.
- R6: Bit 3 (RX empty) sets on the edge where the receive count changes to 0. It is sticky.
- R7: A `clr_evt` pulse clears bits 0 to 5 and bit 9 at the next edge. If an event for a flag occurs in the same cycle as the clear, that flag ends up set.
- R8: A push while the count is DEPTH, or a pop while the count is 0, is ignored and leaves the count unchanged. It sets bit 6 for the transmit side or bit 7 for the receive side.
- R9: `clr_evt` does not clear bits 6 or 7. A `tx_side_rst` pulse clears the transmit count and bits 0, 1, 2 and 6. A `rx_side_rst` pulse clears the receive count and bits 3, 4, 5, 7 and 9.
- R10: Bit 8 shows the `tx_lock` level sampled at the previous edge. It is not sticky and `clr_evt` does not affect it.
- R11: A legal push and a legal pop on the same queue in the same cycle leave its count unchanged and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_push | input | 1 | Transmit queue write strobe |
| tx_pop | input | 1 | Transmit queue read strobe |
| rx_push | input | 1 | Receive queue write strobe |
| rx_pop | input | 1 | Receive queue read strobe |
| tx_level | input | CW | Transmit threshold |
| rx_level_a | input | CW | First receive threshold |
| rx_level_b | input | CW | Second receive threshold |
| clr_evt | input | 1 | Clear-status command |
| tx_lock | input | 1 | Transmit lock level |
| tx_side_rst | input | 1 | Transmit side reset |
| rx_side_rst | input | 1 | Receive side reset |
| status | output | 32 | Packed status word |

## Verification
A wrong internal count shows at the ports only when a later event fires at the wrong time. The bench therefore drains each queue and checks that the empty flag appears on exactly the pop that reaches zero. This makes a miscount after an ignored access, or after a simultaneous push and pop, visible within one queue depth of strobes. A flag register that drops or sets wrongly shows in the status word one edge after the strobe that caused it. Checks sample at the falling edge that follows that rising edge.

// File: rtl/fes_pkg.sv
// Package: bit positions of the status word shared by the unit and its checker.
// Assumes a 32-bit status word; unused positions read as zero.
package fes_pkg;
    localparam int STATUS_W     = 32;
    localparam int B_TX_EMPTY   = 0;
    localparam int B_TX_FULL    = 1;
    localparam int B_TX_LEVEL   = 2;
    localparam int B_RX_EMPTY   = 3;
    localparam int B_RX_FULL    = 4;
    localparam int B_RX_LEVEL_A = 5;
    localparam int B_TX_PERR    = 6;
    localparam int B_RX_PERR    = 7;
    localparam int B_TX_LOCK    = 8;
    localparam int B_RX_LEVEL_B = 9;
endpackage

// File: rtl/fes_level_tracker.sv
// Occupancy tracker for one queue. It counts legal pushes and pops and flags
// illegal ones (push at full, pop at empty), which are dropped. It emits
// single-cycle event pulses for the transitions into empty, into full, and
// onto each of NTHR thresholds. Events are combinational from the strobes and
// the current count. A side reset zeroes the count and suppresses all events.
module fes_level_tracker #(
    parameter int DEPTH = 16,
    parameter int NTHR  = 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     side_rst,
    input  logic                     push,
    input  logic                     pop,
    input  logic [NTHR-1:0][CW-1:0]  thr,
    output logic                     evt_empty,
    output logic                     evt_full,
    output logic [NTHR-1:0]          evt_thr,
    output logic                     evt_perr
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          push_ok;
    logic          pop_ok;
    logic          moved;

    // Qualify strobes against the current occupancy and form the next count.
    always_comb begin
        push_ok = push && (cnt_q != FULL_CNT);
        pop_ok  = pop  && (cnt_q != '0);
        unique case ({push_ok, pop_ok})
            2'b10:   cnt_nxt = cnt_q + CW'(1);
            2'b01:   cnt_nxt = cnt_q - CW'(1);
            default: cnt_nxt = cnt_q;
        endcase
        moved = (push_ok != pop_ok) && !side_rst;
    end

    // Occupancy register; cleared by global or side reset.
    always_ff @(posedge clk) begin
        if (!rst_n || side_rst) cnt_q <= '0;
        else                    cnt_q <= cnt_nxt;
    end

    assign evt_empty = moved && (cnt_nxt == '0);
    assign evt_full  = moved && (cnt_nxt == FULL_CNT);
    assign evt_perr  = !side_rst &&
                       ((push && (cnt_q == FULL_CNT)) || (pop && (cnt_q == '0)));

    // One comparator per threshold, firing only when the count moves onto it.
    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        assign evt_thr[i] = moved && (cnt_nxt == thr[i]);
    end
endmodule

// File: rtl/fes_sticky_bank.sv
// Bank of W sticky flags. A set pulse latches a flag. The soft clear drops all
// flags unless the same bit is being set in that cycle. The hard clear (and
// the global reset) drops everything unconditionally.
module fes_sticky_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hard_clr,
    input  logic         soft_clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] flags
);
    // Flag update: set has priority over the soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr) flags <= '0;
        else                    flags <= (flags & ~{W{soft_clr}}) | set;
    end
endmodule

// File: rtl/fifo_evt_status.sv
// Top of the sticky FIFO event status unit. It holds one tracker per queue,
// sticky banks for the event flags (soft-clearable) and for the pointer-error
// flags (cleared only by side reset), a registered lock level, and the packing
// of all of these into the 32-bit status word. The queue storage is assumed to
// be elsewhere and to obey the same full/empty rules.
module fifo_evt_status #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level_a,
    input  logic [CW-1:0] rx_level_b,
    input  logic          clr_evt,
    input  logic          tx_lock,
    input  logic          tx_side_rst,
    input  logic          rx_side_rst,
    output logic [31:0]   status
);
    import fes_pkg::*;

    logic       tx_e, tx_f, tx_p;
    logic [0:0] tx_t;
    logic       rx_e, rx_f, rx_p;
    logic [1:0] rx_t;
    logic [2:0] tx_flags;
    logic [3:0] rx_flags;
    logic [1:0] perr_flags;
    logic       lock_q;

    fes_level_tracker #(.DEPTH(DEPTH), .NTHR(1)) u_tx_trk (
        .clk(clk), .rst_n(rst_n), .side_rst(tx_side_rst),
        .push(tx_push), .pop(tx_pop), .thr(tx_level),
        .evt_empty(tx_e), .evt_full(tx_f), .evt_thr(tx_t), .evt_perr(tx_p)
    );

    fes_level_tracker #(.DEPTH(DEPTH), .NTHR(2)) u_rx_trk (
        .clk(clk), .rst_n(rst_n), .side_rst(rx_side_rst),
        .push(rx_push), .pop(rx_pop), .thr({rx_level_b, rx_level_a}),
        .evt_empty(rx_e), .evt_full(rx_f), .evt_thr(rx_t), .evt_perr(rx_p)
    );

    // Transmit events: {threshold, full, empty}.
    fes_sticky_bank #(.W(3)) u_tx_evt (
        .clk(clk), .rst_n(rst_n), .hard_clr(tx_side_rst), .soft_clr(clr_evt),
        .set({tx_t[0], tx_f, tx_e}), .flags(tx_flags)
    );

    // Receive events: {threshold b, threshold a, full, empty}.
    fes_sticky_bank #(.W(4)) u_rx_evt (
        .clk(clk), .rst_n(rst_n), .hard_clr(rx_side_rst), .soft_clr(clr_evt),
        .set({rx_t[1], rx_t[0], rx_f, rx_e}), .flags(rx_flags)
    );

    // Pointer errors, one bank per side so each side reset clears its own.
    fes_sticky_bank #(.W(1)) u_tx_perr (
        .clk(clk), .rst_n(rst_n), .hard_clr(tx_side_rst), .soft_clr(1'b0),
        .set(tx_p), .flags(perr_flags[0])
    );
    fes_sticky_bank #(.W(1)) u_rx_perr (
        .clk(clk), .rst_n(rst_n), .hard_clr(rx_side_rst), .soft_clr(1'b0),
        .set(rx_p), .flags(perr_flags[1])
    );

    // Lock level register; live level, not sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= tx_lock;
    end

    // Pack flags into the status word; unused positions stay zero.
    always_comb begin
        status               = '0;
        status[B_TX_EMPTY]   = tx_flags[0];
        status[B_TX_FULL]    = tx_flags[1];
        status[B_TX_LEVEL]   = tx_flags[2];
        status[B_RX_EMPTY]   = rx_flags[0];
        status[B_RX_FULL]    = rx_flags[1];
        status[B_RX_LEVEL_A] = rx_flags[2];
        status[B_RX_LEVEL_B] = rx_flags[3];
        status[B_TX_PERR]    = perr_flags[0];
        status[B_RX_PERR]    = perr_flags[1];
        status[B_TX_LOCK]    = lock_q;
    end
endmodule

// File: rtl/fes_status_chk.sv
// Checker for the event status unit, attached by bind. It observes ports only
// and relates them across one clock edge.
module fes_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_push,
    input logic        tx_pop,
    input logic        rx_push,
    input logic        rx_pop,
    input logic        clr_evt,
    input logic        tx_lock,
    input logic        tx_side_rst,
    input logic        rx_side_rst,
    input logic [31:0] status
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> status == 32'h0);

    // R2
    tx_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr_evt && !tx_side_rst) |=> status[0]);

    // R7
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !tx_push && !tx_pop && !rx_push && !rx_pop)
        |=> (status[5:0] == 6'h0 && !status[9]));

    // R8
    tx_perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(tx_push || tx_pop));

    // R9
    rx_perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !rx_side_rst) |=> status[7]);

    // R10
    lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status[8] == $past(tx_lock));
endmodule

bind fifo_evt_status fes_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_pop(rx_pop), .clr_evt(clr_evt), .tx_lock(tx_lock),
    .tx_side_rst(tx_side_rst), .rx_side_rst(rx_side_rst), .status(status)
);

// File: tb/fifo_evt_status_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module fifo_evt_status_tb;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [CW-1:0] tx_level = '0, rx_level_a = '0, rx_level_b = '0;
    logic          clr_evt = 0, tx_lock = 0, tx_side_rst = 0, rx_side_rst = 0;
    logic [31:0]   status;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fifo_evt_status #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_level(tx_level),
        .rx_level_a(rx_level_a), .rx_level_b(rx_level_b), .clr_evt(clr_evt),
        .tx_lock(tx_lock), .tx_side_rst(tx_side_rst), .rx_side_rst(rx_side_rst),
        .status(status)
    );

    task automatic expect_status(input string req, input logic [31:0] exp);
        checks++;
        if (status !== exp) begin
            errors++;
            $display("FAIL %s: status=%h expected=%h", req, status, exp);
        end
    endtask

    // One cycle of strobes: driven after a falling edge, result seen at the next.
    task automatic strobe(input logic tp, tpo, rp, rpo, clr);
        tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo; clr_evt = clr;
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; clr_evt = 0;
    endtask

    task automatic repeat_strobe(input int n, input logic tp, tpo, rp, rpo);
        for (int i = 0; i < n; i++) strobe(tp, tpo, rp, rpo, 1'b0);
    endtask

    task automatic t_reset;
        expect_status("R1 reset", 32'h0);
    endtask

    task automatic t_tx_flow;
        tx_level = CW'(3);
        repeat_strobe(2, 1, 0, 0, 0);
        expect_status("R4 below threshold", 32'h0);
        repeat_strobe(1, 1, 0, 0, 0);
        expect_status("R4 threshold hit", 32'h4);
        repeat_strobe(13, 1, 0, 0, 0);
        expect_status("R3 tx full", 32'h6);
        repeat_strobe(1, 1, 0, 0, 0);
        expect_status("R8 push at full", 32'h46);
        repeat_strobe(15, 0, 1, 0, 0);
        expect_status("R8 overflow ignored, not empty yet", 32'h46);
        repeat_strobe(1, 0, 1, 0, 0);
        expect_status("R2 tx empty", 32'h47);
        repeat_strobe(2, 1, 0, 0, 0);
        expect_status("R2 empty sticky after pushes", 32'h47);
        strobe(0, 0, 0, 0, 1);
        expect_status("R9 perr survives clear (R7)", 32'h40);
        tx_side_rst = 1; @(negedge clk); tx_side_rst = 0;
        expect_status("R9 tx side reset", 32'h0);
    endtask

    task automatic t_clear_collision;
        tx_level = CW'(1);
        strobe(1, 0, 0, 0, 1);
        expect_status("R7 set wins over clear", 32'h4);
        strobe(0, 0, 0, 0, 1);
        expect_status("R7 clear", 32'h0);
    endtask

    task automatic t_push_pop_same;
        tx_level = CW'(2);
        strobe(1, 1, 0, 0, 0);
        expect_status("R11 no event on push+pop", 32'h0);
        strobe(0, 1, 0, 0, 0);
        expect_status("R11 count kept at one", 32'h1);
        strobe(0, 0, 0, 0, 1);
        expect_status("R7 clear", 32'h0);
    endtask

    task automatic t_rx_flow;
        rx_level_a = CW'(4);
        rx_level_b = CW'(10);
        repeat_strobe(4, 0, 0, 1, 0);
        expect_status("R5 first threshold", 32'h20);
        repeat_strobe(6, 0, 0, 1, 0);
        expect_status("R5 second threshold", 32'h220);
        repeat_strobe(6, 0, 0, 1, 0);
        expect_status("R3 rx full", 32'h230);
        repeat_strobe(15, 0, 0, 0, 1);
        expect_status("R6 rx not empty yet", 32'h230);
        repeat_strobe(1, 0, 0, 0, 1);
        expect_status("R6 rx empty", 32'h238);
        repeat_strobe(1, 0, 0, 0, 1);
        expect_status("R8 pop at empty", 32'h2B8);
        strobe(0, 0, 0, 0, 1);
        expect_status("R9 rx perr survives clear", 32'h80);
        rx_level_a = CW'(1);
        repeat_strobe(1, 0, 0, 1, 0);
        expect_status("R8 underflow ignored", 32'hA0);
        rx_side_rst = 1; @(negedge clk); rx_side_rst = 0;
        expect_status("R9 rx side reset", 32'h0);
    endtask

    task automatic t_lock;
        tx_lock = 1;
        @(negedge clk);
        expect_status("R10 lock shown", 32'h100);
        strobe(0, 0, 0, 0, 1);
        expect_status("R10 lock unaffected by clear", 32'h100);
        rst_n = 0;
        @(negedge clk);
        expect_status("R1 reset overrides lock", 32'h0);
        rst_n = 1;
        tx_lock = 0;
        @(negedge clk);
        expect_status("R10 lock released", 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tx_flow();
        t_clear_collision();
        t_push_pop_same();
        t_rx_flow();
        t_lock();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule